// File: doc/BRIEF.md
# Aliasing Bus Address Decoder

This block sits on a 24-bit system bus and works out, for every access, which target behind the bus should respond. A target can be the main RAM, the cartridge ROM, the boot ROM, a write-only mode register, the colour table, the graphics-processor control registers, the graphics-processor local RAM, a status register or a control register. The choice depends on the address and on the direction of the access. The decoder drives a one-hot select and a byte offset local to the matched window in the same cycle as the strobe. The memories and registers use those to do their part of the access.

Several address windows can lead to one target. The main RAM is repeated four times. The colour table is decoded twice. The graphics control registers and the graphics local RAM each have a second window. That second window sits a fixed distance above the first and takes writes only. One register pair shares a single address: a read reaches the status register, and a write reaches the control register. For reads, the decoder takes the word returned by the selected target and picks out the addressed byte or halfword. It registers the result and flags it valid one cycle later. A read that reaches nothing returns all ones.

Top module: `alias_bus_decoder`

## Requirements
- R1: Main RAM answers at 0x000000–0x7FFFFF as four 2 MiB windows. Every window selects the RAM target with offset equal to the address modulo 0x200000, for both reads and writes.
- R2: The cartridge ROM spans 0x800000–0xDFFEFF and the boot ROM spans 0xE00000–0xE1FFFF. A read selects the matching ROM. A write to either produces no select. Addresses 0xDFFF00 and 0xE20000 do not match a ROM.
- R3: The mode register at 0xF00028–0xF00029 is selected by writes only. A read there produces no select and returns all ones.
- R4: An address in no window produces no select and a zero offset. A read there returns all ones in the lanes the size covers: 0x000000FF for a byte, 0x0000FFFF for a word, 0xFFFFFFFF for a long.
- R5: At 0xF10032–0xF10033, a read selects the status target and a write selects the control target. No access selects both.
- R6: The colour table is decoded at 0xF00400–0xF005FF and again at 0xF00600–0xF007FF. Both select one target with offset equal to the address modulo 0x200, so a write through one half is read back through the other.
- R7: The graphics control registers are at 0xF02100–0xF0211F and the graphics RAM at 0xF03000–0xF03FFF. Both are also reachable 0x8000 higher, and those upper windows select the same target and offset for writes only. A read in an upper window produces no select and returns all ones.
- R8: Size codes are 0 for byte, 1 for word, 2 or 3 for long. Read data equals the target word shifted right by 8 × (offset bits [1:0]), then masked to 8, 16 or 32 bits.
- R9: rd_valid rises in the cycle after each cycle in which only bus_rd is high. rd_data holds the read result in that cycle. rd_valid is low after any other cycle.
- R10: Select bit positions are RAM 0, cartridge ROM 1, boot ROM 2, mode register 3, colour table 4, graphics control 5, graphics RAM 6, status 7, control 8. At most one bit is high. The select and offset follow the address in the same cycle. With no strobe, or with both strobes, the select is zero.
- R11: While rst is high at a clock edge, rd_valid and rd_data are cleared to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2/3 long |
| tgt_sel | output | 9 | One-hot target select, combinational |
| tgt_offset | output | 24 | Byte offset within the matched window |
| tgt_rdata | input | 288 | Read words from the nine targets, target k in bits 32k+31:32k |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | Read result valid, one cycle after the read strobe |

## Verification
The select and the offset are combinational. The bench therefore drives each access just after a falling edge and compares both against its own window model one nanosecond later, before the next rising edge. Read data and rd_valid pass through one register. They are compared at the following falling edge, after exactly one rising edge, and an idle cycle between accesses shows rd_valid returning low. The expected read value comes from the bench's own stub contents, shifted and masked as the size rule states. Aliased and mirrored writes are confirmed by reading the stored word back through a different window.

// File: rtl/abd_pkg.sv
package abd_pkg;

  // Targets behind the decoder; the index is the bit position in tgt_sel.
  localparam int NTGT    = 9;
  localparam int T_RAM   = 0;
  localparam int T_CROM  = 1;
  localparam int T_BROM  = 2;
  localparam int T_WOREG = 3;
  localparam int T_PAL   = 4;
  localparam int T_GCTL  = 5;
  localparam int T_GRAM  = 6;
  localparam int T_STAT  = 7;
  localparam int T_CTRL  = 8;

  // Which directions a window accepts.
  typedef enum logic [1:0] {
    K_RW    = 2'd0,
    K_RO    = 2'd1,
    K_WO    = 2'd2,
    K_SPLIT = 2'd3   // read reaches status, write reaches control
  } win_kind_e;

endpackage

// File: rtl/abd_win_match.sv
module abd_win_match #(
  parameter int          AW = 24,
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] LO_A = LO[AW-1:0];
  localparam logic [AW-1:0] HI_A = HI[AW-1:0];

  generate
    if (LO == 0) begin : g_from_zero
      assign hit = (addr <= HI_A);
    end else begin : g_range
      assign hit = (addr >= LO_A) && (addr <= HI_A);
    end
  endgenerate
endmodule

// File: rtl/abd_first_hit.sv
module abd_first_hit #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest index (lowest address) wins when windows overlap.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/abd_rd_format.sv
module abd_rd_format #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          have_src,
  input  logic [DW-1:0] word,
  input  logic [LW-1:0] lane,
  input  logic [1:0]    size,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] mask;
  logic [DW-1:0] shifted;
  logic [DW-1:0] nxt;

  always_comb begin
    case (size)
      2'd0:    mask = DW'(8'hFF);
      2'd1:    mask = DW'(16'hFFFF);
      default: mask = '1;
    endcase
    shifted = word >> {lane, 3'b000};
    nxt     = have_src ? (shifted & mask) : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= nxt;
    end
  end
endmodule

// File: rtl/alias_bus_decoder.sv
module alias_bus_decoder
  import abd_pkg::*;
#(
  parameter int          AW          = 24,
  parameter int          DW          = 32,
  parameter int          RAM_LOG2    = 21,
  parameter int          RAM_MIRRORS = 4,
  parameter int unsigned CROM_BASE   = 32'h0080_0000,
  parameter int unsigned CROM_LAST   = 32'h00DF_FEFF,
  parameter int unsigned BROM_BASE   = 32'h00E0_0000,
  parameter int unsigned BROM_LAST   = 32'h00E1_FFFF,
  parameter int unsigned WOREG_BASE  = 32'h00F0_0028,
  parameter int unsigned PAL_BASE    = 32'h00F0_0400,
  parameter int          PAL_LOG2    = 9,
  parameter int          PAL_COPIES  = 2,
  parameter int unsigned GCTL_BASE   = 32'h00F0_2100,
  parameter int          GCTL_LOG2   = 5,
  parameter int unsigned GRAM_BASE   = 32'h00F0_3000,
  parameter int          GRAM_LOG2   = 12,
  parameter int unsigned ALIAS_DIST  = 32'h0000_8000,
  parameter int unsigned PAIR_BASE   = 32'h00F1_0032,
  parameter int unsigned REG_BYTES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [1:0]          bus_size,
  output logic [NTGT-1:0]     tgt_sel,
  output logic [AW-1:0]       tgt_offset,
  input  logic [NTGT*DW-1:0]  tgt_rdata,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid
);
  // Window order follows ascending address; first_hit keeps the lowest.
  localparam int IX_CROM = RAM_MIRRORS;
  localparam int IX_BROM = IX_CROM + 1;
  localparam int IX_WO   = IX_CROM + 2;
  localparam int IX_PAL  = IX_CROM + 3;
  localparam int IX_GCTL = IX_PAL + PAL_COPIES;
  localparam int IX_GRAM = IX_GCTL + 1;
  localparam int IX_GCA  = IX_GCTL + 2;
  localparam int IX_GRA  = IX_GCTL + 3;
  localparam int IX_PAIR = IX_GCTL + 4;
  localparam int NW      = IX_PAIR + 1;
  localparam int IW      = $clog2(NW);
  localparam int TW      = $clog2(NTGT);
  localparam int LW      = $clog2(DW / 8);

  function automatic int unsigned w_base(input int i);
    if (i < IX_CROM)       return i * (32'd1 << RAM_LOG2);
    else if (i == IX_CROM) return CROM_BASE;
    else if (i == IX_BROM) return BROM_BASE;
    else if (i == IX_WO)   return WOREG_BASE;
    else if (i < IX_GCTL)  return PAL_BASE + (i - IX_PAL) * (32'd1 << PAL_LOG2);
    else if (i == IX_GCTL) return GCTL_BASE;
    else if (i == IX_GRAM) return GRAM_BASE;
    else if (i == IX_GCA)  return GCTL_BASE + ALIAS_DIST;
    else if (i == IX_GRA)  return GRAM_BASE + ALIAS_DIST;
    else                   return PAIR_BASE;
  endfunction

  function automatic int unsigned w_span(input int i);
    if (i < IX_CROM)                      return 32'd1 << RAM_LOG2;
    else if (i == IX_CROM)                return CROM_LAST - CROM_BASE + 1;
    else if (i == IX_BROM)                return BROM_LAST - BROM_BASE + 1;
    else if (i == IX_WO)                  return REG_BYTES;
    else if (i < IX_GCTL)                 return 32'd1 << PAL_LOG2;
    else if (i == IX_GCTL || i == IX_GCA) return 32'd1 << GCTL_LOG2;
    else if (i == IX_GRAM || i == IX_GRA) return 32'd1 << GRAM_LOG2;
    else                                  return REG_BYTES;
  endfunction

  function automatic int w_tgt(input int i);
    if (i < IX_CROM)                      return T_RAM;
    else if (i == IX_CROM)                return T_CROM;
    else if (i == IX_BROM)                return T_BROM;
    else if (i == IX_WO)                  return T_WOREG;
    else if (i < IX_GCTL)                 return T_PAL;
    else if (i == IX_GCTL || i == IX_GCA) return T_GCTL;
    else if (i == IX_GRAM || i == IX_GRA) return T_GRAM;
    else                                  return T_STAT;
  endfunction

  function automatic win_kind_e w_kind(input int i);
    if (i < IX_CROM)                      return K_RW;
    else if (i == IX_CROM || i == IX_BROM) return K_RO;
    else if (i == IX_WO)                  return K_WO;
    else if (i < IX_GCA)                  return K_RW;
    else if (i == IX_GCA || i == IX_GRA)  return K_WO;
    else                                  return K_SPLIT;
  endfunction

  logic [NW-1:0] win_hit;
  logic [AW-1:0] base_tab [NW];
  logic [TW-1:0] tgt_tab  [NW];
  win_kind_e     kind_tab [NW];

  generate
    for (genvar gi = 0; gi < NW; gi++) begin : g_win
      abd_win_match #(
        .AW (AW),
        .LO (w_base(gi)),
        .HI (w_base(gi) + w_span(gi) - 1)
      ) u_match (
        .addr (bus_addr),
        .hit  (win_hit[gi])
      );
      assign base_tab[gi] = AW'(w_base(gi));
      assign tgt_tab[gi]  = TW'(w_tgt(gi));
      assign kind_tab[gi] = w_kind(gi);
    end
  endgenerate

  logic          found;
  logic [IW-1:0] win;

  abd_first_hit #(.N(NW), .IW(IW)) u_pick (
    .hit   (win_hit),
    .found (found),
    .idx   (win)
  );

  logic      is_rd, is_wr, allow;
  logic [TW-1:0] tgt;
  win_kind_e kind;

  always_comb begin
    is_rd = bus_rd & ~bus_wr;
    is_wr = bus_wr & ~bus_rd;
    kind  = kind_tab[win];
    case (kind)
      K_RO:    allow = is_rd;
      K_WO:    allow = is_wr;
      default: allow = is_rd | is_wr;
    endcase
    tgt = (kind == K_SPLIT && is_wr) ? TW'(T_CTRL) : tgt_tab[win];
    tgt_sel = '0;
    if (found && allow) tgt_sel[tgt] = 1'b1;
    tgt_offset = found ? (bus_addr - base_tab[win]) : '0;
  end

  logic [DW-1:0] src_word;
  assign src_word = tgt_rdata[int'(tgt) * DW +: DW];

  abd_rd_format #(.DW(DW), .LW(LW)) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .capture  (is_rd),
    .have_src (|tgt_sel),
    .word     (src_word),
    .lane     (tgt_offset[LW-1:0]),
    .size     (bus_size),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/abd_chk.sv
module abd_chk
  import abd_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [NTGT-1:0] tgt_sel,
  input logic            rd_valid
);
  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));

  // R10
  idle_nosel_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd == bus_wr) |-> (tgt_sel == '0));

  // R9
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> rd_valid);

  // R9
  rvalid_only_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> !rd_valid);

  // R5
  pair_write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> !tgt_sel[T_STAT]);

  // R5
  pair_read_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |-> !tgt_sel[T_CTRL]);

  // R2
  rom_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> !(tgt_sel[T_CROM] || tgt_sel[T_BROM]));

  // R3
  woreg_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |-> !tgt_sel[T_WOREG]);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !rd_valid);
endmodule

bind alias_bus_decoder abd_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .tgt_sel  (tgt_sel),
  .rd_valid (rd_valid)
);

// File: tb/alias_bus_decoder_test.sv
module alias_bus_decoder_test;
  import abd_pkg::*;

  localparam int NT = NTGT;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [23:0]      bus_addr = '0;
  logic             bus_rd = 1'b0;
  logic             bus_wr = 1'b0;
  logic [1:0]       bus_size = '0;
  logic [NT-1:0]    tgt_sel;
  logic [23:0]      tgt_offset;
  logic [NT*DW-1:0] tgt_rdata;
  logic [31:0]      rd_data;
  logic             rd_valid;
  logic [31:0]      wdata = '0;

  logic [31:0] ram_m  [64];
  logic [31:0] pal_m  [128];
  logic [31:0] gctl_m [8];
  logic [31:0] gram_m [64];
  logic [31:0] ctrl_q = '0;
  logic [31:0] wo_q = '0;

  int tests = 0;
  int fails = 0;

  alias_bus_decoder uut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_rd (bus_rd),
    .bus_wr (bus_wr), .bus_size (bus_size), .tgt_sel (tgt_sel),
    .tgt_offset (tgt_offset), .tgt_rdata (tgt_rdata),
    .rd_data (rd_data), .rd_valid (rd_valid)
  );

  // Target stubs: combinational read words from the offset.
  assign tgt_rdata[T_RAM*DW   +: DW] = ram_m[tgt_offset[7:2]];
  assign tgt_rdata[T_CROM*DW  +: DW] = {8'hC0, tgt_offset};
  assign tgt_rdata[T_BROM*DW  +: DW] = {8'hB0, tgt_offset};
  assign tgt_rdata[T_WOREG*DW +: DW] = 32'hDEAD_0001;
  assign tgt_rdata[T_PAL*DW   +: DW] = pal_m[tgt_offset[8:2]];
  assign tgt_rdata[T_GCTL*DW  +: DW] = gctl_m[tgt_offset[4:2]];
  assign tgt_rdata[T_GRAM*DW  +: DW] = gram_m[tgt_offset[7:2]];
  assign tgt_rdata[T_STAT*DW  +: DW] = {8'h5A, tgt_offset};
  assign tgt_rdata[T_CTRL*DW  +: DW] = 32'hDEAD_0002;

  always @(posedge clk) begin
    if (bus_wr && !bus_rd) begin
      if (tgt_sel[T_RAM])   ram_m[tgt_offset[7:2]]  <= wdata;
      if (tgt_sel[T_PAL])   pal_m[tgt_offset[8:2]]  <= wdata;
      if (tgt_sel[T_GCTL])  gctl_m[tgt_offset[4:2]] <= wdata;
      if (tgt_sel[T_GRAM])  gram_m[tgt_offset[7:2]] <= wdata;
      if (tgt_sel[T_CTRL])  ctrl_q <= wdata;
      if (tgt_sel[T_WOREG]) wo_q   <= wdata;
    end
  end

  function automatic logic [31:0] stub_word(input int t, input logic [23:0] off);
    case (t)
      T_RAM:   return ram_m[off[7:2]];
      T_CROM:  return {8'hC0, off};
      T_BROM:  return {8'hB0, off};
      T_PAL:   return pal_m[off[8:2]];
      T_GCTL:  return gctl_m[off[4:2]];
      T_GRAM:  return gram_m[off[7:2]];
      T_STAT:  return {8'h5A, off};
      default: return 32'hDEAD_0000;
    endcase
  endfunction

  function automatic logic [31:0] fmt(input logic [31:0] w, input logic [1:0] sz,
                                      input logic [1:0] lane);
    logic [31:0] m;
    m = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return (w >> (8 * lane)) & m;
  endfunction

  // Independent window model written from the requirements.
  function automatic void exp_dec(input logic [23:0] a, input logic r, input logic w,
                                  output logic [NT-1:0] sel, output logic [23:0] off);
    int t;
    bit can_r, can_w, hit;
    t = 0; can_r = 0; can_w = 0; hit = 1; off = '0;
    if (a <= 24'h7FFFFF) begin
      t = T_RAM; off = a & 24'h1FFFFF; can_r = 1; can_w = 1;
    end else if (a <= 24'hDFFEFF) begin
      t = T_CROM; off = a - 24'h800000; can_r = 1;
    end else if (a >= 24'hE00000 && a <= 24'hE1FFFF) begin
      t = T_BROM; off = a - 24'hE00000; can_r = 1;
    end else if (a == 24'hF00028 || a == 24'hF00029) begin
      t = T_WOREG; off = a - 24'hF00028; can_w = 1;
    end else if (a >= 24'hF00400 && a <= 24'hF007FF) begin
      t = T_PAL; off = a & 24'h0001FF; can_r = 1; can_w = 1;
    end else if (a >= 24'hF02100 && a <= 24'hF0211F) begin
      t = T_GCTL; off = a - 24'hF02100; can_r = 1; can_w = 1;
    end else if (a >= 24'hF03000 && a <= 24'hF03FFF) begin
      t = T_GRAM; off = a - 24'hF03000; can_r = 1; can_w = 1;
    end else if (a >= 24'hF0A100 && a <= 24'hF0A11F) begin
      t = T_GCTL; off = a - 24'hF0A100; can_w = 1;
    end else if (a >= 24'hF0B000 && a <= 24'hF0BFFF) begin
      t = T_GRAM; off = a - 24'hF0B000; can_w = 1;
    end else if (a == 24'hF10032 || a == 24'hF10033) begin
      t = T_STAT; off = a - 24'hF10032; can_r = 1; can_w = 1;
    end else begin
      hit = 0;
    end
    sel = '0;
    if (hit && r && !w && can_r) sel[t] = 1'b1;
    if (hit && w && !r && can_w) sel[(t == T_STAT) ? T_CTRL : t] = 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic r, input logic w,
                        input logic [1:0] sz, input logic [31:0] wd, input string tag);
    logic [NT-1:0] es;
    logic [23:0]   eo;
    logic [31:0]   ed;
    int            et;
    bit            isrd;
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_size = sz; wdata = wd;
    exp_dec(a, r, w, es, eo);
    isrd = r && !w;
    ed = '0;
    et = 0;
    for (int k = 0; k < NT; k++) if (es[k]) et = k;
    if (isrd) ed = (es != '0) ? fmt(stub_word(et, eo), sz, eo[1:0])
                              : fmt(32'hFFFF_FFFF, sz, 2'd0);
    #1;
    check(tgt_sel == es, {tag, " select"}, 32'(tgt_sel), 32'(es));
    check(tgt_offset == eo, {tag, " offset"}, 32'(tgt_offset), 32'(eo));
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check(rd_valid == isrd, {tag, " R9 valid"}, 32'(rd_valid), 32'(isrd));
    if (isrd) check(rd_data == ed, {tag, " data"}, rd_data, ed);
  endtask

  initial begin
    for (int i = 0; i < 64; i++)  ram_m[i]  = 32'h1000_0000 + i;
    for (int i = 0; i < 128; i++) pal_m[i]  = 32'h2000_0000 + i;
    for (int i = 0; i < 8; i++)   gctl_m[i] = 32'h3000_0000 + i;
    for (int i = 0; i < 64; i++)  gram_m[i] = 32'h4000_0000 + i;
  end

  initial begin
    #(8 * 100000);
    fails++; tests++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [23:0] ra;
    logic        rr, rw;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(rd_valid == 1'b0, "R11 reset valid", 32'(rd_valid), 32'd0);
    check(rd_data == '0, "R11 reset data", rd_data, 32'd0);
    check(tgt_sel == '0, "R10 idle select", 32'(tgt_sel), 32'd0);
    rst = 1'b0;

    // R1 mirrors share storage
    access(24'h600010, 1'b0, 1'b1, 2'd2, 32'h1122_3344, "R1 write mirror 3");
    access(24'h000010, 1'b1, 1'b0, 2'd2, 32'h0, "R1 long via window 0");
    access(24'h000011, 1'b1, 1'b0, 2'd0, 32'h0, "R8 byte lane 1");
    access(24'h200012, 1'b1, 1'b0, 2'd1, 32'h0, "R8 word lane 2");
    access(24'h7FFFFF, 1'b1, 1'b0, 2'd0, 32'h0, "R1 top of mirrors");
    // R2 ROM bounds and write blocking
    access(24'hDFFEFF, 1'b1, 1'b0, 2'd0, 32'h0, "R2 cart ROM last byte");
    access(24'hDFFF00, 1'b1, 1'b0, 2'd2, 32'h0, "R2 past cart ROM");
    access(24'hE1FFFF, 1'b1, 1'b0, 2'd0, 32'h0, "R2 boot ROM last byte");
    access(24'hE20000, 1'b1, 1'b0, 2'd1, 32'h0, "R2 past boot ROM");
    access(24'h800000, 1'b0, 1'b1, 2'd2, 32'h5, "R2 ROM write ignored");
    // R3 write-only register
    access(24'hF00028, 1'b1, 1'b0, 2'd1, 32'h0, "R3 read of mode reg");
    access(24'hF00028, 1'b0, 1'b1, 2'd1, 32'h0000_ABCD, "R3 write of mode reg");
    check(wo_q == 32'h0000_ABCD, "R3 mode reg stored", wo_q, 32'h0000_ABCD);
    // R4 unmapped
    access(24'hF00100, 1'b1, 1'b0, 2'd2, 32'h0, "R4 unmapped long");
    access(24'hF00100, 1'b1, 1'b0, 2'd0, 32'h0, "R4 unmapped byte");
    // R5 split pair
    access(24'hF10032, 1'b1, 1'b0, 2'd1, 32'h0, "R5 pair read status");
    access(24'hF10032, 1'b0, 1'b1, 2'd1, 32'h0000_7777, "R5 pair write control");
    check(ctrl_q == 32'h0000_7777, "R5 control stored", ctrl_q, 32'h0000_7777);
    // R6 colour table halves
    access(24'hF00604, 1'b0, 1'b1, 2'd2, 32'hCAFE_F00D, "R6 write upper half");
    access(24'hF00404, 1'b1, 1'b0, 2'd2, 32'h0, "R6 read lower half");
    // R7 write-only aliases
    access(24'hF0B020, 1'b0, 1'b1, 2'd2, 32'h600D_BEEF, "R7 write GPU RAM alias");
    access(24'hF03020, 1'b1, 1'b0, 2'd2, 32'h0, "R7 read GPU RAM direct");
    access(24'hF0B020, 1'b1, 1'b0, 2'd2, 32'h0, "R7 read via alias");
    access(24'hF0A108, 1'b0, 1'b1, 2'd2, 32'h0BAD_CAFE, "R7 write ctrl alias");
    access(24'hF02108, 1'b1, 1'b0, 2'd3, 32'h0, "R7 read ctrl direct");
    // R10 both strobes
    access(24'h000020, 1'b1, 1'b1, 2'd2, 32'h9, "R10 both strobes");
    access(24'hF02100, 1'b0, 1'b0, 2'd2, 32'h0, "R10 no strobe");

    for (int n = 0; n < 400; n++) begin
      case ($urandom % 8)
        0: ra = 24'($urandom);
        1: ra = 24'($urandom) & 24'h7FFFFF;
        2: ra = 24'hF00400 + 24'($urandom % 32'h400);
        3: ra = 24'hF02100 + 24'($urandom % 32'h40);
        4: ra = 24'hF03000 + 24'($urandom % 32'h1000);
        5: ra = 24'hF0A100 + 24'($urandom % 32'h40);
        6: ra = 24'hF0B000 + 24'($urandom % 32'h1000);
        default: begin
          case ($urandom % 8)
            0: ra = 24'hF00028; 1: ra = 24'hF10033; 2: ra = 24'hDFFEFF;
            3: ra = 24'hDFFF00; 4: ra = 24'hE1FFFF; 5: ra = 24'hE20000;
            6: ra = 24'h7FFFFF; default: ra = 24'hF00029;
          endcase
        end
      endcase
      case ($urandom % 4)
        0, 1:    begin rr = 1'b1; rw = 1'b0; end
        2:       begin rr = 1'b0; rw = 1'b1; end
        default: begin rr = 1'b1; rw = 1'b1; end
      endcase
      access(ra, rr, rw, 2'($urandom), $urandom, "R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule